// File: doc/BRIEF.md
# Linked-List Display Fetch Engine

This block feeds a display controller. It follows a circular chain of four-word descriptors in memory. Each descriptor names the next descriptor, a source buffer, a frame identifier and a command. The command carries a word count and flags. For each descriptor the engine pulls the source buffer through a single-outstanding burst read port. Pixel words go into an output FIFO, which the panel timing logic drains one word per pop. A flag in the command sends a buffer into an internal palette RAM instead. The panel side reads that RAM by entry index. Because the chain loops back on itself, a frame repeats with no host action.

Software builds the chain once: either a palette descriptor and a frame descriptor pointing at each other, or one frame descriptor pointing at itself. It sets the first descriptor address and raises `enable`. Start-of-frame and end-of-frame pulses are raised for descriptors that ask for them. An empty FIFO at pop time sets a sticky underrun flag. With protection on, the output then holds its last word.

Top module: `dfetch_top`

## Requirements
- R1: During and right after reset, `mem_req`, `irq_sof`, `irq_eof` and `uflow` are low and `pix_word` is zero.
- R2: With the engine idle and `enable` high at a clock edge, the next cycle shows `mem_req` high with `mem_addr` = `first_desc_addr` and `mem_len` = 4. Request, address and length hold until `mem_gnt`.
- R3: Descriptor words are read in the order next pointer, source address, frame identifier, command. Command bits 23:0 are the length in 32-bit words. `frame_id` shows the third word of the latest descriptor.
- R4: Data bursts use the length coded on `burst_sel`: 0=4, 1=8, 2=16, 3=32, 4=64 words, and 5 to 7 give 16. Each burst of a descriptor starts 4×length bytes after the previous one, the first at the source address.
- R5: Exactly the command's length of words reaches the pixel stream, in address order. Words of a final partial burst beyond the length are dropped.
- R6: Command bit 28 routes the words into the palette RAM, not the FIFO, starting at palette word 0. Entry i is the low half (i even) or high half (i odd) of palette word i/2. It appears on `pal_entry` the cycle after `pal_idx` is presented.
- R7: Command bit 31 gives a one-cycle `irq_sof` in the cycle after the last descriptor word arrives. Bit 30 gives a one-cycle `irq_eof` in the cycle after the descriptor's last data word arrives.
- R8: When a descriptor completes, its next pointer is fetched if `enable` is high; otherwise the engine goes idle and issues no requests.
- R9: No data burst for the pixel stream is requested while FIFO free space is smaller than the burst. The FIFO never overflows.
- R10: `pix_pop` with a non-empty FIFO puts the oldest word on `pix_word` the following cycle.
- R11: `pix_pop` with an empty FIFO sets `uflow`, which stays set until reset. `pix_word` then holds its value if `uflow_protect` is high, and becomes zero if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the chain; sampled at idle and at each descriptor end |
| first_desc_addr | input | 32 | Byte address of the first descriptor |
| burst_sel | input | 3 | Data burst length code |
| uflow_protect | input | 1 | Hold last output word on underrun |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 7 | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| pix_pop | input | 1 | Panel side takes one word |
| pix_word | output | 32 | Output pixel word |
| uflow | output | 1 | Sticky underrun flag |
| pal_idx | input | log2(PAL_WORDS)+1 | Palette entry index |
| pal_entry | output | 16 | Palette entry, one cycle after index |
| irq_sof | output | 1 | Start-of-frame pulse |
| irq_eof | output | 1 | End-of-frame pulse |
| frame_id | output | 32 | Identifier of the current descriptor |

## Verification
The request is due one cycle after `enable` is sampled. It is checked at the falling edge after that single rising edge, with the grant held off so it can be seen. A popped word lands on `pix_word` one cycle after the edge that samples `pix_pop`. The scoreboard therefore compares at the next falling edge, against a queue filled from the data region each time `irq_sof` shows the next frame has been loaded. Palette entries are read one cycle after the index is set. Stall and idle behaviour are checked by grant counts that stay the same over long windows.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
   localparam int CMD_LEN_W   = 24;
   localparam int CMD_SOF_BIT = 31;
   localparam int CMD_EOF_BIT = 30;
   localparam int CMD_PAL_BIT = 28;
   localparam int DESC_WORDS  = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DREQ, ST_DRECV, ST_XREQ, ST_XRECV, ST_DONE
   } fetch_st_t;

   function automatic logic [6:0] burst_words(input logic [2:0] code);
      case (code)
         3'd0:    return 7'd4;
         3'd1:    return 7'd8;
         3'd2:    return 7'd16;
         3'd3:    return 7'd32;
         3'd4:    return 7'd64;
         default: return 7'd16;
      endcase
   endfunction
endpackage

// File: rtl/dfetch_fifo.sv
module dfetch_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [DW-1:0]             wdata,
   input  logic                      pop,
   output logic [DW-1:0]             head,
   output logic                      empty,
   output logic                      full,
   output logic [$clog2(DEPTH):0]    free
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   assign head  = store[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign free  = (AW+1)'(DEPTH) - cnt;
endmodule

// File: rtl/dfetch_palram.sv
module dfetch_palram #(
   parameter int WORDS = 128
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [$clog2(WORDS)-1:0]   waddr,
   input  logic [31:0]                wdata,
   input  logic [$clog2(WORDS):0]     ridx,
   output logic [15:0]                rentry
);
   localparam int IW = $clog2(WORDS);

   logic [31:0] ram [WORDS];

   always_ff @(posedge clk) begin
      if (we) ram[waddr] <= wdata;
      rentry <= ridx[0] ? ram[ridx[IW:1]][31:16] : ram[ridx[IW:1]][15:0];
   end
endmodule

// File: rtl/dfetch_engine.sv
module dfetch_engine
   import dfetch_pkg::*;
#(
   parameter int FIFO_CW = 8,
   parameter int PAL_AW  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [31:0]         first_desc,
   input  logic [2:0]          burst_sel,
   output logic                mem_req,
   output logic [31:0]         mem_addr,
   output logic [6:0]          mem_len,
   input  logic                mem_gnt,
   input  logic                mem_rvalid,
   input  logic [31:0]         mem_rdata,
   input  logic [FIFO_CW-1:0]  fifo_free,
   output logic                fifo_push,
   output logic [31:0]         fifo_wdata,
   output logic                pal_we,
   output logic [PAL_AW-1:0]   pal_waddr,
   output logic [31:0]         pal_wdata,
   output logic                irq_sof,
   output logic                irq_eof,
   output logic [31:0]         frame_id
);
   fetch_st_t             st;
   logic [31:0]           desc_ptr, nxt_ptr, src_ptr;
   logic [CMD_LEN_W-1:0]  rem;
   logic [6:0]            beat, blen, blen_sel;
   logic                  is_pal, want_eof, sof_q;
   logic [PAL_AW:0]       pal_ptr;
   logic                  room, keep, beat_in;

   assign blen_sel  = burst_words(burst_sel);
   assign room      = is_pal || (int'(fifo_free) >= int'(blen_sel));
   assign mem_req   = (st == ST_DREQ) || ((st == ST_XREQ) && room);
   assign mem_addr  = (st == ST_DREQ) ? desc_ptr : src_ptr;
   assign mem_len   = (st == ST_DREQ) ? 7'(DESC_WORDS) : blen_sel;
   assign beat_in   = (st == ST_XRECV) && mem_rvalid;
   assign keep      = ({(CMD_LEN_W-7)'(0), beat} < rem);
   assign fifo_push = beat_in && keep && !is_pal;
   assign fifo_wdata = mem_rdata;
   assign pal_we    = beat_in && keep && is_pal && !pal_ptr[PAL_AW];
   assign pal_waddr = pal_ptr[PAL_AW-1:0];
   assign pal_wdata = mem_rdata;
   assign irq_sof   = sof_q;
   assign irq_eof   = (st == ST_DONE) && want_eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         desc_ptr <= '0;
         nxt_ptr  <= '0;
         src_ptr  <= '0;
         rem      <= '0;
         beat     <= '0;
         blen     <= 7'd4;
         is_pal   <= 1'b0;
         want_eof <= 1'b0;
         sof_q    <= 1'b0;
         pal_ptr  <= '0;
         frame_id <= '0;
      end else begin
         sof_q <= 1'b0;
         case (st)
            ST_IDLE: if (enable) begin
               desc_ptr <= first_desc;
               st       <= ST_DREQ;
            end
            ST_DREQ: if (mem_gnt) begin
               beat <= '0;
               st   <= ST_DRECV;
            end
            ST_DRECV: if (mem_rvalid) begin
               beat <= beat + 7'd1;
               case (beat[1:0])
                  2'd0: nxt_ptr  <= mem_rdata;
                  2'd1: src_ptr  <= mem_rdata;
                  2'd2: frame_id <= mem_rdata;
                  default: begin
                     rem      <= mem_rdata[CMD_LEN_W-1:0];
                     is_pal   <= mem_rdata[CMD_PAL_BIT];
                     want_eof <= mem_rdata[CMD_EOF_BIT];
                     sof_q    <= mem_rdata[CMD_SOF_BIT];
                     if (mem_rdata[CMD_PAL_BIT]) pal_ptr <= '0;
                     st <= (mem_rdata[CMD_LEN_W-1:0] == '0) ? ST_DONE : ST_XREQ;
                  end
               endcase
            end
            ST_XREQ: if (mem_req && mem_gnt) begin
               blen <= blen_sel;
               beat <= '0;
               st   <= ST_XRECV;
            end
            ST_XRECV: if (mem_rvalid) begin
               beat <= beat + 7'd1;
               if (pal_we) pal_ptr <= pal_ptr + (PAL_AW+1)'(1);
               if (beat == blen - 7'd1) begin
                  src_ptr <= src_ptr + {23'd0, blen, 2'b00};
                  if (rem <= {(CMD_LEN_W-7)'(0), blen}) begin
                     rem <= '0;
                     st  <= ST_DONE;
                  end else begin
                     rem <= rem - {(CMD_LEN_W-7)'(0), blen};
                     st  <= ST_XREQ;
                  end
               end
            end
            ST_DONE: begin
               desc_ptr <= nxt_ptr;
               st       <= enable ? ST_DREQ : ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top #(
   parameter int FIFO_DEPTH = 128,
   parameter int PAL_WORDS  = 128,
   parameter bit PAL_ENABLE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic [31:0]                   first_desc_addr,
   input  logic [2:0]                    burst_sel,
   input  logic                          uflow_protect,
   output logic                          mem_req,
   output logic [31:0]                   mem_addr,
   output logic [6:0]                    mem_len,
   input  logic                          mem_gnt,
   input  logic                          mem_rvalid,
   input  logic [31:0]                   mem_rdata,
   input  logic                          pix_pop,
   output logic [31:0]                   pix_word,
   output logic                          uflow,
   input  logic [$clog2(PAL_WORDS):0]    pal_idx,
   output logic [15:0]                   pal_entry,
   output logic                          irq_sof,
   output logic                          irq_eof,
   output logic [31:0]                   frame_id
);
   localparam int FIFO_CW = $clog2(FIFO_DEPTH) + 1;
   localparam int PAL_AW  = $clog2(PAL_WORDS);

   if (FIFO_DEPTH < 64 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
      $error("FIFO_DEPTH must be a power of two of at least 64");
   end
   if (PAL_WORDS < 2 || (PAL_WORDS & (PAL_WORDS - 1)) != 0) begin : g_bad_pal
      $error("PAL_WORDS must be a power of two of at least 2");
   end

   logic                fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [31:0]         fifo_wdata, fifo_head;
   logic [FIFO_CW-1:0]  fifo_free;
   logic                pal_we;
   logic [PAL_AW-1:0]   pal_waddr;
   logic [31:0]         pal_wdata;

   dfetch_engine #(.FIFO_CW(FIFO_CW), .PAL_AW(PAL_AW)) u_eng (
      .clk(clk), .rst_n(rst_n), .enable(enable), .first_desc(first_desc_addr),
      .burst_sel(burst_sel), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .fifo_free(fifo_free), .fifo_push(fifo_push),
      .fifo_wdata(fifo_wdata), .pal_we(pal_we), .pal_waddr(pal_waddr),
      .pal_wdata(pal_wdata), .irq_sof(irq_sof), .irq_eof(irq_eof),
      .frame_id(frame_id)
   );

   dfetch_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
      .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
      .free(fifo_free)
   );

   if (PAL_ENABLE) begin : g_pal
      dfetch_palram #(.WORDS(PAL_WORDS)) u_pal (
         .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
         .ridx(pal_idx), .rentry(pal_entry)
      );
   end else begin : g_nopal
      assign pal_entry = '0;
   end

   assign fifo_pop = pix_pop && !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_word <= '0;
         uflow    <= 1'b0;
      end else if (pix_pop) begin
         if (!fifo_empty) begin
            pix_word <= fifo_head;
         end else begin
            uflow <= 1'b1;
            if (!uflow_protect) pix_word <= '0;
         end
      end
   end
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req,
   input logic        mem_gnt,
   input logic [31:0] mem_addr,
   input logic [6:0]  mem_len,
   input logic        fifo_push,
   input logic        fifo_full,
   input logic        fifo_empty,
   input logic [31:0] fifo_head,
   input logic        irq_sof,
   input logic        irq_eof,
   input logic        uflow,
   input logic        pix_pop,
   input logic [31:0] pix_word,
   input logic        uflow_protect
);
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));

   assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_len == 7'd4 || mem_len == 7'd8 || mem_len == 7'd16 ||
                   mem_len == 7'd32 || mem_len == 7'd64));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   assert_sof_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sof |=> !irq_sof);

   assert_eof_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eof |=> !irq_eof);

   assert_pop_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_pop && !fifo_empty |=> pix_word == $past(fifo_head));

   assert_uflow_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pix_pop && fifo_empty |=> uflow);

   assert_uflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> uflow);

   assert_protect_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pix_pop && fifo_empty && uflow_protect |=> $stable(pix_word));
endmodule

bind dfetch_top dfetch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
   .mem_addr(mem_addr), .mem_len(mem_len), .fifo_push(fifo_push),
   .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
   .irq_sof(irq_sof), .irq_eof(irq_eof), .uflow(uflow), .pix_pop(pix_pop),
   .pix_word(pix_word), .uflow_protect(uflow_protect)
);

// File: tb/dfetch_top_tb.sv
module dfetch_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] first_desc_addr = '0;
   logic [2:0]  burst_sel = '0;
   logic        uflow_protect = 1'b0;
   logic        mem_req, mem_gnt;
   logic [31:0] mem_addr;
   logic [6:0]  mem_len;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        pix_pop = 1'b0;
   logic [31:0] pix_word;
   logic        uflow;
   logic [7:0]  pal_idx = '0;
   logic [15:0] pal_entry;
   logic        irq_sof, irq_eof;
   logic [31:0] frame_id;

   int checks = 0, failures = 0;
   logic [31:0] mem [0:1023];
   bit   gnt_en = 1'b0;
   int   rd_left = 0;
   logic [31:0] rd_addr = '0;
   int   gnt_cnt = 0;
   int   exp_blen = 4;
   logic [31:0] cur_src = '0;
   int   cur_len = 0;
   logic [31:0] exp_q [$];
   bit   pop_en = 1'b0, force_req = 1'b0, forced = 1'b0;
   int   pop_div = 4;
   int   cyc = 0, sof_cnt = 0, eof_cnt = 0;

   always #4 clk = ~clk;

   dfetch_top u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .first_desc_addr(first_desc_addr),
      .burst_sel(burst_sel), .uflow_protect(uflow_protect), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_pop(pix_pop),
      .pix_word(pix_word), .uflow(uflow), .pal_idx(pal_idx), .pal_entry(pal_entry),
      .irq_sof(irq_sof), .irq_eof(irq_eof), .frame_id(frame_id)
   );

   assign mem_gnt = mem_req & gnt_en;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: one burst at a time, one beat per cycle
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (rd_left > 0) begin
         mem_rvalid <= 1'b1;
         mem_rdata  <= mem[rd_addr[11:2]];
         rd_addr    <= rd_addr + 32'd4;
         rd_left    <= rd_left - 1;
      end else if (mem_req && mem_gnt) begin
         rd_addr <= mem_addr;
         rd_left <= int'(mem_len);
         gnt_cnt <= gnt_cnt + 1;
         if (mem_addr >= 32'h400) begin
            chk(int'(mem_len) == exp_blen, "R4 burst length", 32'(mem_len), 32'(exp_blen));
            chk(((mem_addr - cur_src) % (exp_blen * 4)) == 0, "R4 burst address step",
                mem_addr, cur_src);
         end
      end
   end

   // monitor and scoreboard
   always @(negedge clk) begin
      cyc++;
      if (rst_n && pix_pop && !forced) begin
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(pix_word == e, "R5 R10 pixel word", pix_word, e);
         end else chk(1'b0, "R10 pop with empty expectation", pix_word, 32'h0);
      end
      if (rst_n && irq_sof) begin
         sof_cnt++;
         for (int i = 0; i < cur_len; i++) exp_q.push_back(mem[(cur_src >> 2) + 32'(i)]);
      end
      if (rst_n && irq_eof) eof_cnt++;
      forced = force_req;
      force_req = 1'b0;
      pix_pop = forced || (pop_en && (cyc % pop_div == 0) && exp_q.size() > 0);
   end

   task automatic do_reset();
      enable = 1'b0;
      pop_en = 1'b0;
      gnt_en = 1'b0;
      rst_n  = 1'b0;
      repeat (4) @(negedge clk);
      exp_q.delete();
      sof_cnt = 0;
      eof_cnt = 0;
      chk(!mem_req && !irq_sof && !irq_eof && !uflow && pix_word == 0, "R1 reset state",
          {mem_req, irq_sof, irq_eof, uflow}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !uflow && pix_word == 0, "R1 after release", pix_word, 32'h0);
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] src,
                           input logic [31:0] fid, input logic [31:0] cmd);
      mem[a[11:2]]     = nx;
      mem[a[11:2] + 1] = src;
      mem[a[11:2] + 2] = fid;
      mem[a[11:2] + 3] = cmd;
   endtask

   task automatic drain_and_idle();
      int guard;
      enable = 1'b0;
      pop_en = 1'b1;
      guard = 0;
      while (exp_q.size() > 0 && guard < 30000) begin
         @(negedge clk);
         guard++;
      end
      chk(exp_q.size() == 0, "R5 all expected words delivered", 32'(exp_q.size()), 32'h0);
      repeat (200) @(negedge clk);
      begin
         int g0;
         g0 = gnt_cnt;
         repeat (100) @(negedge clk);
         chk(!mem_req && gnt_cnt == g0, "R8 idle after enable low", 32'(gnt_cnt), 32'(g0));
      end
      pop_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic force_pop();
      @(posedge clk);
      force_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 + 32'(i);

      // ---- A: self-looping frame, burst 4, length 10 (final burst partial)
      put_desc(32'h100, 32'h100, 32'h400, 32'h55, (32'h1 << 31) | (32'h1 << 30) | 32'd10);
      cur_src = 32'h400; cur_len = 10; exp_blen = 4;
      burst_sel = 3'd0;
      first_desc_addr = 32'h100;
      do_reset();
      enable = 1'b1;
      @(negedge clk);
      chk(mem_req && mem_addr == 32'h100 && mem_len == 7'd4, "R2 first descriptor request",
          mem_addr, 32'h100);
      repeat (3) @(negedge clk);
      chk(mem_req && mem_addr == 32'h100, "R2 request held without grant", mem_addr, 32'h100);
      gnt_en = 1'b1;
      repeat (1500) @(negedge clk);
      begin
         int g0;
         g0 = gnt_cnt;
         repeat (300) @(negedge clk);
         chk(gnt_cnt == g0, "R9 no burst while FIFO lacks room", 32'(gnt_cnt), 32'(g0));
      end
      chk(frame_id == 32'h55, "R3 frame identifier", frame_id, 32'h55);
      chk(!uflow, "R11 no underrun while fed", 32'(uflow), 32'h0);
      drain_and_idle();
      chk(sof_cnt == eof_cnt && sof_cnt > 2, "R7 sof and eof per frame", 32'(sof_cnt), 32'(eof_cnt));
      begin
         logic [31:0] last;
         last = pix_word;
         uflow_protect = 1'b1;
         force_pop();
         chk(uflow && pix_word == last, "R11 protected underrun holds word", pix_word, last);
         uflow_protect = 1'b0;
         force_pop();
         chk(uflow && pix_word == 32'h0, "R11 unprotected underrun gives zero", pix_word, 32'h0);
      end

      // ---- B: palette then frame, burst 8, frame length 20
      for (int w = 0; w < 8; w++)
         mem[(32'h600 >> 2) + w] = {16'h1000 + 16'(2*w + 1), 16'h1000 + 16'(2*w)};
      put_desc(32'h200, 32'h210, 32'h600, 32'h1, (32'h1 << 28) | (32'h1 << 30) | 32'd8);
      put_desc(32'h210, 32'h200, 32'h800, 32'h77, (32'h1 << 31) | 32'd20);
      cur_src = 32'h800; cur_len = 20; exp_blen = 8;
      burst_sel = 3'd1;
      first_desc_addr = 32'h200;
      do_reset();
      gnt_en = 1'b1;
      enable = 1'b1;
      repeat (300) @(negedge clk);
      pop_en = 1'b1;
      repeat (2500) @(negedge clk);
      drain_and_idle();
      chk(sof_cnt >= 2 && (sof_cnt == eof_cnt || sof_cnt == eof_cnt - 1),
          "R8 chain alternates palette and frame", 32'(sof_cnt), 32'(eof_cnt));
      chk(frame_id == 32'h77, "R3 frame identifier of frame descriptor", frame_id, 32'h77);
      for (int i = 0; i < 16; i++) begin
         pal_idx = 8'(i);
         @(negedge clk);
         chk(pal_entry == 16'h1000 + 16'(i), "R6 palette entry", 32'(pal_entry), 32'h1000 + 32'(i));
      end

      // ---- C: burst 64, length 3
      put_desc(32'h300, 32'h300, 32'hA00, 32'h9, (32'h1 << 31) | (32'h1 << 30) | 32'd3);
      cur_src = 32'hA00; cur_len = 3; exp_blen = 64;
      burst_sel = 3'd4;
      first_desc_addr = 32'h300;
      pop_div = 64;
      do_reset();
      gnt_en = 1'b1;
      enable = 1'b1;
      repeat (400) @(negedge clk);
      pop_en = 1'b1;
      repeat (1500) @(negedge clk);
      drain_and_idle();
      chk(sof_cnt == eof_cnt && sof_cnt > 0, "R7 pulses with long bursts", 32'(sof_cnt), 32'(eof_cnt));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule